// File: doc/BRIEF.md
# Extended-Address Serial Management Register Slave

This block is a register slave on the two-wire serial management bus used by Ethernet PHYs: a management clock from the host and one bidirectional data line. It decodes standard read and write frames and gives the host access to a bank of 16-bit internal registers. It answers only frames whose 5-bit PHY address has its top bit set, which is addresses 16 to 31. Ordinary PHYs can therefore sit on the same bus at addresses 0 to 15, and this slave ignores frames sent to them.

The PHY address field serves as extra address bits. Its low four bits are placed above the 5-bit register field to form a 9-bit internal index, `index = phy[3:0]*32 + reg`. The bank holds `BANK_DEPTH` words. Indices at or above the depth read as zero, and writes to them are discarded. All logic runs on the management clock. The data line is split into an input, an output and an output enable, and an external tristate pad joins them.

Top module: `mdio_reg_slave`

## Requirements
- R1: After reset `mdio_oe` is 0 and every bank register reads back as 0x0000.
- R2: A frame is recognised only after at least `PRE_LEN` (32) consecutive 1 bits followed by the start bits 0 then 1. With 31 ones the frame is ignored. With exactly 32 ones the frame is accepted.
- R3: Frames whose PHY address is 0 to 15 are ignored. A read is not answered (`mdio_oe` stays 0) and a write changes no register, including the register whose index would alias to the same low bits.
- R4: The internal index is {phy[3:0], reg[4:0]}. For example, PHY 17 with register 2 is index 34, and PHY 16 with register 2 is index 2.
- R5: On a read (opcode bits 1,0), counting rising edges from the one that samples the last register-address bit, the slave:
  - leaves MDIO released for the first turnaround bit;
  - drives 0 for the second turnaround bit;
  - drives the 16 data bits MSB first, each changing just after a rising edge;
  - releases the line on the edge after the last data bit.
- R6: On a write (opcode bits 0,1), the slave takes turnaround bits 1,0 and then 16 data bits MSB first. It stores the word in the bank on the rising edge after the last data bit. A later read returns the stored word.
- R7: A write whose turnaround bits are not 1,0 is discarded.
- R8: Opcodes 0,0 and 1,1 are ignored. The slave does not drive the line and changes no register.
- R9: With the default `BANK_DEPTH` of 64, indices 64 to 511 read as 0 and writes to them are discarded. Such a write must not wrap onto a low index.
- R10: A new frame may follow the previous one directly, provided its preamble is long enough.
- R11: After a valid preamble, a start pattern other than 0,1 returns the slave to preamble search without driving. The next correct frame is served normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; MDIO is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value the slave drives |
| mdio_oe | output | 1 | Drive enable for the data pad (1 = slave drives) |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble threshold and a 64-word bank behind the 9-bit index. With a shallow bank, both the in-range index extremes (0 and 63) and the out-of-range indices (64 and 511) can be reached within a handful of frames. This exposes truncation aliasing, where index 64 would land on index 0. The exact preamble threshold is tested on both sides (31 and 32 ones). The bench also samples the turnaround and data bits half a clock after each rising edge, which checks the edge on which each bit appears.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

    localparam int OP_W = 2;

    localparam logic [OP_W-1:0] OP_READ  = 2'b10;
    localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_HDR,
        ST_RD_TA,
        ST_RD_DATA,
        ST_WR_TA1,
        ST_WR_TA2,
        ST_WR_DATA
    } mdio_st_e;

endpackage

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank #(
    parameter int AW    = 9,
    parameter int DW    = 16,
    parameter int DEPTH = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i
);

    localparam int          IW    = $clog2(DEPTH);
    localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    logic          rd_in, wr_in;
    logic [IW-1:0] rd_idx, wr_idx;

    assign rd_in  = {1'b0, rd_addr_i} < LIMIT;
    assign wr_in  = {1'b0, wr_addr_i} < LIMIT;
    assign rd_idx = rd_addr_i[IW-1:0];
    assign wr_idx = wr_addr_i[IW-1:0];

    assign rd_data_o = rd_in ? mem_q[rd_idx] : '0;

    always_comb begin
        mem_d = mem_q;
        if (wr_en_i && wr_in) begin
            mem_d[wr_idx] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // R6
    write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_in) |=> (mem_q[$past(wr_idx)] == $past(wr_data_i)));

endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_slave_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PHY_W   = 5,
    parameter int REG_W   = 5,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = PHY_W - 1 + REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o
);

    localparam int HDR_W = OP_W + PHY_W + REG_W;
    localparam int MAXC  = (DATA_W > HDR_W) ? DATA_W : HDR_W;
    localparam int CW    = $clog2(MAXC + 1);
    localparam int OW    = $clog2(PRE_LEN + 1);

    typedef struct packed {
        mdio_st_e          st;
        logic [CW-1:0]     cnt;
        logic [OW-1:0]     ones;
        logic [HDR_W-1:0]  hdr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] sh;
        logic              oe;
        logic              out;
        logic              we;
    } fsm_t;

    fsm_t s_d, s_q;

    logic [HDR_W-1:0] hdr_nx;
    logic [OP_W-1:0]  op_nx;
    logic [PHY_W-1:0] phy_nx;
    logic [REG_W-1:0] reg_nx;

    assign hdr_nx = {s_q.hdr[HDR_W-2:0], mdio_i};
    assign op_nx  = hdr_nx[HDR_W-1 -: OP_W];
    assign phy_nx = hdr_nx[REG_W +: PHY_W];
    assign reg_nx = hdr_nx[REG_W-1:0];

    always_comb begin
        s_d    = s_q;
        s_d.we = 1'b0;
        unique case (s_q.st)
            ST_HUNT: begin
                if (mdio_i) begin
                    if (s_q.ones != OW'(PRE_LEN)) s_d.ones = s_q.ones + 1'b1;
                end else if (s_q.ones >= OW'(PRE_LEN)) begin
                    s_d.st   = ST_START;
                    s_d.ones = '0;
                end else begin
                    s_d.ones = '0;
                end
            end
            ST_START: begin
                s_d.ones = '0;
                s_d.cnt  = '0;
                s_d.st   = mdio_i ? ST_HDR : ST_HUNT;
            end
            ST_HDR: begin
                s_d.hdr = hdr_nx;
                if (s_q.cnt == CW'(HDR_W - 1)) begin
                    s_d.addr = {phy_nx[PHY_W-2:0], reg_nx};
                    s_d.cnt  = '0;
                    s_d.ones = '0;
                    if (!phy_nx[PHY_W-1])        s_d.st = ST_HUNT;
                    else if (op_nx == OP_READ)   s_d.st = ST_RD_TA;
                    else if (op_nx == OP_WRITE)  s_d.st = ST_WR_TA1;
                    else                         s_d.st = ST_HUNT;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_RD_TA: begin
                s_d.oe  = 1'b1;
                s_d.out = 1'b0;
                s_d.sh  = rd_data_i;
                s_d.cnt = '0;
                s_d.st  = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                if (s_q.cnt == CW'(DATA_W)) begin
                    s_d.oe   = 1'b0;
                    s_d.out  = 1'b0;
                    s_d.st   = ST_HUNT;
                    s_d.ones = OW'(mdio_i);
                end else begin
                    s_d.out = s_q.sh[DATA_W-1];
                    s_d.sh  = {s_q.sh[DATA_W-2:0], 1'b0};
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_WR_TA1: begin
                s_d.st = mdio_i ? ST_WR_TA2 : ST_HUNT;
            end
            ST_WR_TA2: begin
                s_d.cnt  = '0;
                s_d.ones = OW'(mdio_i);
                s_d.st   = mdio_i ? ST_HUNT : ST_WR_DATA;
            end
            ST_WR_DATA: begin
                s_d.sh = {s_q.sh[DATA_W-2:0], mdio_i};
                if (s_q.cnt == CW'(DATA_W - 1)) begin
                    s_d.we   = 1'b1;
                    s_d.st   = ST_HUNT;
                    s_d.ones = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HUNT, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mdio_o    = s_q.out;
    assign mdio_oe   = s_q.oe;
    assign rd_addr_o = s_q.addr;
    assign wr_addr_o = s_q.addr;
    assign wr_data_o = s_q.sh;
    assign wr_en_o   = s_q.we;

    logic [CW-1:0] chk_oe_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       chk_oe_run_q <= '0;
        else if (mdio_oe) chk_oe_run_q <= chk_oe_run_q + 1'b1;
        else              chk_oe_run_q <= '0;
    end

    // R5
    ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R5
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (chk_oe_run_q < CW'(DATA_W + 1)));

    // R6
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);

    // R6
    no_write_while_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> !wr_en_o);

endmodule

// File: rtl/mdio_reg_slave.sv
module mdio_reg_slave #(
    parameter int PRE_LEN    = 32,
    parameter int PHY_W      = 5,
    parameter int REG_W      = 5,
    parameter int DATA_W     = 16,
    parameter int BANK_DEPTH = 64
) (
    input  logic mdc,
    input  logic rst_n,
    input  logic mdio_i,
    output logic mdio_o,
    output logic mdio_oe
);

    localparam int ADDR_W = PHY_W - 1 + REG_W;

    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;

    mdio_frame_fsm #(
        .PRE_LEN (PRE_LEN),
        .PHY_W   (PHY_W),
        .REG_W   (REG_W),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W)
    ) u_fsm (
        .clk       (mdc),
        .rst_n     (rst_n),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data)
    );

    mdio_reg_bank #(
        .AW    (ADDR_W),
        .DW    (DATA_W),
        .DEPTH (BANK_DEPTH)
    ) u_bank (
        .clk       (mdc),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

endmodule

// File: tb/mdio_reg_slave_test.sv
module mdio_reg_slave_test;

    localparam int CLK_PERIOD = 20;

    logic mdc    = 1'b0;
    logic rst_n  = 1'b0;
    logic mdio_m = 1'b1;
    logic mdio_bus;
    logic mdio_o, mdio_oe;

    int errs   = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) mdc = ~mdc;

    assign mdio_bus = mdio_oe ? mdio_o : mdio_m;

    mdio_reg_slave uut (
        .mdc     (mdc),
        .rst_n   (rst_n),
        .mdio_i  (mdio_bus),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge mdc);
        mdio_m = b;
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg);
        for (int i = 0; i < pre; i++) drive_bit(1'b1);
        drive_bit(st[1]); drive_bit(st[0]);
        drive_bit(op[1]); drive_bit(op[0]);
        for (int i = 4; i >= 0; i--) drive_bit(phy[i]);
        for (int i = 4; i >= 0; i--) drive_bit(rg[i]);
    endtask

    task automatic do_read(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input bit claimed, input logic [15:0] exp, input string req);
        logic [19:0] oe_v;
        logic [19:0] o_v;
        logic [15:0] data;
        oe_v = '0;
        o_v  = '0;
        send_hdr(pre, st, op, phy, rg);
        for (int i = 1; i <= 19; i++) begin
            @(negedge mdc);
            oe_v[i] = mdio_oe;
            o_v[i]  = mdio_o;
            mdio_m  = 1'b1;
        end
        if (claimed) begin
            for (int k = 0; k < 16; k++) data[15-k] = o_v[3+k];
            // R5: released in TA1, zero in TA2, drive through last data bit, then release
            check(oe_v == 20'h7FFFC && !o_v[2], "R5", "turnaround and drive window",
                  {11'b0, o_v[2], oe_v}, {12'b0, 20'h7FFFC});
            check(data == exp, req, $sformatf("read data phy=%0d reg=%0d", phy, rg),
                  {16'b0, data}, {16'b0, exp});
        end else begin
            check(oe_v == '0, req, $sformatf("no drive phy=%0d reg=%0d", phy, rg),
                  {12'b0, oe_v}, 32'h0);
        end
    endtask

    task automatic do_write(input int pre, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] rg,
                            input logic [1:0] ta, input logic [15:0] data);
        send_hdr(pre, 2'b01, op, phy, rg);
        drive_bit(ta[1]); drive_bit(ta[0]);
        for (int i = 15; i >= 0; i--) drive_bit(data[i]);
        drive_bit(1'b1); drive_bit(1'b1);
    endtask

    task automatic t_reset();
        check(mdio_oe == 1'b0, "R1", "oe during reset", {31'b0, mdio_oe}, 32'h0);
        rst_n = 1'b1;
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd0, 1, 16'h0000, "R1");
        do_read(32, 2'b01, 2'b10, 5'd17, 5'd31, 1, 16'h0000, "R1");
    endtask

    task automatic t_rw_basic();
        do_write(32, 2'b01, 5'd16, 5'd5, 2'b10, 16'hA5C3);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd5, 1, 16'hA5C3, "R6");
    endtask

    task automatic t_addr_map();
        do_write(32, 2'b01, 5'd17, 5'd2, 2'b10, 16'h1234);
        do_write(32, 2'b01, 5'd16, 5'd2, 2'b10, 16'hBEEF);
        do_read(32, 2'b01, 2'b10, 5'd17, 5'd2, 1, 16'h1234, "R4");
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd2, 1, 16'hBEEF, "R4");
        do_write(32, 2'b01, 5'd17, 5'd31, 2'b10, 16'h0F0F);
        do_read(32, 2'b01, 2'b10, 5'd17, 5'd31, 1, 16'h0F0F, "R4");
    endtask

    task automatic t_out_of_range();
        do_write(32, 2'b01, 5'd31, 5'd31, 2'b10, 16'h5555);
        do_read(32, 2'b01, 2'b10, 5'd31, 5'd31, 1, 16'h0000, "R9");
        do_write(32, 2'b01, 5'd18, 5'd0, 2'b10, 16'h1111);
        do_read(32, 2'b01, 2'b10, 5'd18, 5'd0, 1, 16'h0000, "R9");
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd0, 1, 16'h0000, "R9");
    endtask

    task automatic t_low_phy();
        do_read(32, 2'b01, 2'b10, 5'd1, 5'd5, 0, 16'h0, "R3");
        do_read(32, 2'b01, 2'b10, 5'd15, 5'd5, 0, 16'h0, "R3");
        do_write(32, 2'b01, 5'd1, 5'd5, 2'b10, 16'hDEAD);
        do_read(32, 2'b01, 2'b10, 5'd17, 5'd5, 1, 16'h0000, "R3");
    endtask

    task automatic t_preamble();
        drive_bit(1'b0); drive_bit(1'b0);
        do_write(31, 2'b01, 5'd16, 5'd7, 2'b10, 16'h7777);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd7, 1, 16'h0000, "R2");
        drive_bit(1'b0); drive_bit(1'b0);
        do_write(32, 2'b01, 5'd16, 5'd7, 2'b10, 16'h7777);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd7, 1, 16'h7777, "R2");
    endtask

    task automatic t_bad_ta();
        do_write(32, 2'b01, 5'd16, 5'd9, 2'b11, 16'h9999);
        do_write(32, 2'b01, 5'd16, 5'd9, 2'b00, 16'h9999);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd9, 1, 16'h0000, "R7");
    endtask

    task automatic t_bad_op();
        do_write(32, 2'b11, 5'd16, 5'd10, 2'b10, 16'hAAAA);
        do_write(32, 2'b00, 5'd16, 5'd10, 2'b10, 16'hAAAA);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd10, 1, 16'h0000, "R8");
        do_read(32, 2'b01, 2'b11, 5'd16, 5'd5, 0, 16'h0, "R8");
        do_read(32, 2'b01, 2'b00, 5'd16, 5'd5, 0, 16'h0, "R8");
    endtask

    task automatic t_bad_start();
        do_read(32, 2'b00, 2'b10, 5'd16, 5'd5, 0, 16'h0, "R11");
        do_read(32, 2'b11, 2'b10, 5'd16, 5'd5, 0, 16'h0, "R11");
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd5, 1, 16'hA5C3, "R11");
    endtask

    task automatic t_back_to_back();
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd5, 1, 16'hA5C3, "R10");
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd2, 1, 16'hBEEF, "R10");
        do_write(32, 2'b01, 5'd16, 5'd12, 2'b10, 16'h8001);
        do_read(32, 2'b01, 2'b10, 5'd16, 5'd12, 1, 16'h8001, "R10");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge mdc);
        t_reset();
        t_rw_basic();
        t_addr_map();
        t_out_of_range();
        t_low_phy();
        t_preamble();
        t_bad_ta();
        t_bad_op();
        t_bad_start();
        t_back_to_back();
        repeat (4) @(negedge mdc);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule